// File: doc/BRIEF.md
# Carry-Chain Prefix Sequencer

This decode-side controller handles a carry prefix instruction. The prefix names a destination register for a final carry and supplies a list of two-bit tags, one per following instruction. The instructions that follow it form its shadow. For each instruction in that shadow, the sequencer states in the same cycle whether the adder must take a carry in, and what that carry is. When the instruction's tag says it produces a carry, the sequencer captures the carry-out that the execution unit returns in that same cycle.

The running carry is kept inside the block. When the shadow ends, the sequencer issues one writeback of the final carry to the register the prefix named. A shadow ends after its last slot, or earlier when a new prefix arrives. This lets a chain of ordinary two-source adds form a wide sum. For example, four 64-bit adds give a 257-bit result: four sum registers plus the carry register. No carry operand or flags register is needed.

Top module: `carry_chain_seq`

## Requirements
- R1: While reset is asserted and after it is released, no shadow is active, `cin_en`, `cin_val` and `wb_valid` are low, and instructions get no carry-in until a prefix is accepted.
- R2: A prefix (`in_valid` and `in_is_prefix` high) opens a shadow whose length is `pfx_count`, clamped to SLOTS. Each later cycle with `in_valid` high and `in_is_prefix` low consumes one slot, in order. Slot k uses tag bits [2k+1:2k]. Cycles with `in_valid` low consume no slot.
- R3: Tag bit 0 set means the slot produces a carry. Tag bit 1 set means it consumes one. So 00 is none, 01 is produce-only, 10 is consume-only and 11 is consume-and-produce.
- R4: In the cycle of a slot whose tag has bit 1 set, `cin_en` is high and `cin_val` equals the pending carry. Otherwise both are low.
- R5: The pending carry is the `ex_cout` sampled in the most recent produce-tagged slot of the same shadow, or 0 if no slot of that shadow has produced yet. Slots tagged 00 or 10 leave it unchanged.
- R6: One cycle after the last slot of a shadow, `wb_valid` is high for one cycle. `wb_reg` then equals the prefix's register field, and `wb_carry` equals the final carry, including the last slot's own carry-out if that slot produces.
- R7: A prefix that arrives while a shadow is active causes a writeback of the old shadow's pending carry and register one cycle later. The new shadow starts with a pending carry of 0.
- R8: Instructions outside any shadow get `cin_en` low and cause no writeback.
- R9: A prefix with `pfx_count` of 0 opens no shadow. It produces no writeback, except the one R7 requires for a shadow it ends.
- R10: A prefix with tags produce-only, then three consume-and-produce, followed by four 64-bit adds, yields four sums and a written-back carry that together equal the 257-bit sum of the two operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_is_prefix | input | 1 | The presented instruction is a carry prefix |
| pfx_reg | input | REG_W | Register that receives the final carry |
| pfx_tags | input | 2*SLOTS | Per-slot tags, slot 0 in the low bits |
| pfx_count | input | $clog2(SLOTS+1) | Number of slots in the shadow |
| ex_cout | input | 1 | Adder carry-out for the current instruction |
| cin_en | output | 1 | Current instruction takes a carry in |
| cin_val | output | 1 | Carry-in value for the current instruction |
| wb_valid | output | 1 | Final carry writeback strobe |
| wb_reg | output | REG_W | Destination register of the writeback |
| wb_carry | output | 1 | Final carry value |

## Verification
The bench builds the block with its defaults: SLOTS of 8 and REG_W of 5. With these values, a count of 12 shows clamping to the full eight-slot shadow, and a 4-bit count field can exceed SLOTS at all. Five-bit register names let the bench tell writebacks of different shadows apart. The bench's own 64-bit adder closes the carry loop. This brings the all-ones operand cases, which carry through every limb, within reach of the 257-bit comparison.

// File: rtl/carry_seq_pkg.sv
package carry_seq_pkg;
  typedef enum logic [1:0] {
    TAG_NONE  = 2'b00,
    TAG_OUT   = 2'b01,
    TAG_IN    = 2'b10,
    TAG_INOUT = 2'b11
  } ctag_e;
endpackage

// File: rtl/cseq_shadow.sv
module cseq_shadow
  import carry_seq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int REG_W = 5,
  localparam int TW = 2 * SLOTS,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_is_prefix,
  input  logic [REG_W-1:0] pfx_reg,
  input  logic [TW-1:0]    pfx_tags,
  input  logic [CW-1:0]    pfx_count,
  output logic             pfx_load,
  output logic             slot_fire,
  output logic             last_slot,
  output logic             preempt,
  output ctag_e            cur_tag,
  output logic [REG_W-1:0] shadow_reg
);
  logic             active_q, active_d;
  logic [CW-1:0]    left_q, left_d;
  logic [TW-1:0]    tags_q, tags_d;
  logic [REG_W-1:0] reg_q, reg_d;
  logic [CW-1:0]    cnt_clamp;
  logic             upd_en;

  assign pfx_load   = in_valid & in_is_prefix;
  assign slot_fire  = in_valid & ~in_is_prefix & active_q;
  assign preempt    = pfx_load & active_q;
  assign last_slot  = slot_fire & (left_q == CW'(1));
  assign cur_tag    = ctag_e'(tags_q[1:0]);
  assign shadow_reg = reg_q;
  assign cnt_clamp  = (pfx_count > CW'(SLOTS)) ? CW'(SLOTS) : pfx_count;
  assign upd_en     = pfx_load | slot_fire;

  always_comb begin
    active_d = active_q;
    left_d   = left_q;
    tags_d   = tags_q;
    reg_d    = reg_q;
    if (pfx_load) begin
      active_d = (cnt_clamp != '0);
      left_d   = cnt_clamp;
      tags_d   = pfx_tags;
      reg_d    = pfx_reg;
    end else if (slot_fire) begin
      active_d = (left_q != CW'(1));
      left_d   = left_q - CW'(1);
      tags_d   = tags_q >> 2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
      tags_q   <= '0;
      reg_q    <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      left_q   <= left_d;
      tags_q   <= tags_d;
      reg_q    <= reg_d;
    end
  end

  // R2
  left_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= CW'(SLOTS));
  // R2
  shadow_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_slot |=> !active_q);
  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_load && pfx_count == '0) |=> !active_q);
endmodule

// File: rtl/cseq_carry.sv
module cseq_carry
  import carry_seq_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pfx_load,
  input  logic             slot_fire,
  input  logic             last_slot,
  input  logic             preempt,
  input  ctag_e            cur_tag,
  input  logic [REG_W-1:0] shadow_reg,
  input  logic             ex_cout,
  output logic             cin_en,
  output logic             cin_val,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_reg,
  output logic             wb_carry
);
  logic [1:0]       tag_bits;
  logic             produce, consume, close;
  logic             pend_q, pend_d, pend_en;
  logic             final_c;
  logic             wbv_q;
  logic [REG_W-1:0] wbr_q;
  logic             wbc_q;

  assign tag_bits = cur_tag;
  assign produce  = slot_fire & tag_bits[0];
  assign consume  = slot_fire & tag_bits[1];
  assign cin_en   = consume;
  assign cin_val  = consume & pend_q;

  assign pend_en  = pfx_load | produce;
  assign pend_d   = pfx_load ? 1'b0 : ex_cout;
  assign close    = last_slot | preempt;
  assign final_c  = (last_slot & produce) ? ex_cout : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbv_q <= 1'b0;
      wbr_q <= '0;
      wbc_q <= 1'b0;
    end else begin
      wbv_q <= close;
      if (close) begin
        wbr_q <= shadow_reg;
        wbc_q <= final_c;
      end
    end
  end

  assign wb_valid = wbv_q;
  assign wb_reg   = wbr_q;
  assign wb_carry = wbc_q;

  // R4
  cin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cin_en |-> !cin_val);
  // R7
  fresh_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_load |=> !pend_q);
  // R6
  wb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(close));
endmodule

// File: rtl/carry_chain_seq.sv
module carry_chain_seq
  import carry_seq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int REG_W = 5,
  localparam int TW = 2 * SLOTS,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_is_prefix,
  input  logic [REG_W-1:0] pfx_reg,
  input  logic [TW-1:0]    pfx_tags,
  input  logic [CW-1:0]    pfx_count,
  input  logic             ex_cout,
  output logic             cin_en,
  output logic             cin_val,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_reg,
  output logic             wb_carry
);
  logic             pfx_load, slot_fire, last_slot, preempt;
  ctag_e            cur_tag;
  logic [REG_W-1:0] shadow_reg;

  cseq_shadow #(.SLOTS(SLOTS), .REG_W(REG_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_prefix(in_is_prefix),
    .pfx_reg(pfx_reg), .pfx_tags(pfx_tags), .pfx_count(pfx_count),
    .pfx_load(pfx_load), .slot_fire(slot_fire), .last_slot(last_slot),
    .preempt(preempt), .cur_tag(cur_tag), .shadow_reg(shadow_reg)
  );

  cseq_carry #(.REG_W(REG_W)) u_carry (
    .clk(clk), .rst_n(rst_n), .pfx_load(pfx_load), .slot_fire(slot_fire),
    .last_slot(last_slot), .preempt(preempt), .cur_tag(cur_tag),
    .shadow_reg(shadow_reg), .ex_cout(ex_cout), .cin_en(cin_en),
    .cin_val(cin_val), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_carry(wb_carry)
  );

  // R1
  idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !wb_valid && !cin_en);
endmodule

// File: tb/sim_carry_chain_seq.sv
module sim_carry_chain_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_is_prefix, ex_cout;
  logic [4:0]  pfx_reg;
  logic [15:0] pfx_tags;
  logic [3:0]  pfx_count;
  logic        cin_en, cin_val, wb_valid, wb_carry;
  logic [4:0]  wb_reg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  bit          m_active;
  int          m_left;
  logic [15:0] m_tags;
  logic [4:0]  m_reg;
  bit          m_pend;
  bit          e_wbv, e_wbc, e_pre;
  logic [4:0]  e_wbr;
  bit          seen_wbc;

  always #10 clk = ~clk;

  carry_chain_seq u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_prefix(in_is_prefix),
    .pfx_reg(pfx_reg), .pfx_tags(pfx_tags), .pfx_count(pfx_count),
    .ex_cout(ex_cout), .cin_en(cin_en), .cin_val(cin_val),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_carry(wb_carry)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit p, input logic [4:0] r,
                     input logic [15:0] t, input logic [3:0] n,
                     input logic [63:0] a, input logic [63:0] b,
                     output logic [63:0] s);
    bit         in_sh, e_en, e_val, c;
    logic [64:0] full;
    string      rq;
    @(negedge clk);
    in_valid = v; in_is_prefix = p; pfx_reg = r; pfx_tags = t; pfx_count = n;
    in_sh = v && !p && m_active;
    e_en  = in_sh && m_tags[1];
    e_val = e_en && m_pend;
    full  = {1'b0, a} + {1'b0, b} + {64'd0, e_val};
    s = full[63:0];
    c = full[64];
    ex_cout = c;
    #2;
    rq = in_sh ? "R4" : "R8";
    chk(cin_en == e_en, rq, "cin_en", cin_en, e_en);
    chk(cin_val == e_val, (in_sh ? "R5" : "R8"), "cin_val", cin_val, e_val);
    chk(wb_valid == e_wbv, (e_pre ? "R7" : "R6"), "wb_valid", wb_valid, e_wbv);
    if (e_wbv) begin
      chk(wb_reg == e_wbr, (e_pre ? "R7" : "R6"), "wb_reg", wb_reg, e_wbr);
      chk(wb_carry == e_wbc, (e_pre ? "R7" : "R6"), "wb_carry", wb_carry, e_wbc);
      seen_wbc = wb_carry;
    end
    // model update for the coming edge
    e_wbv = 0; e_pre = 0;
    if (v && p) begin
      if (m_active) begin
        e_wbv = 1; e_pre = 1; e_wbr = m_reg; e_wbc = m_pend;
      end
      m_left = (n > 8) ? 8 : int'(n);
      m_active = (m_left != 0);
      m_tags = t; m_reg = r; m_pend = 0;
    end else if (in_sh) begin
      if (m_tags[0]) m_pend = c;
      m_tags = m_tags >> 2;
      m_left--;
      if (m_left == 0) begin
        m_active = 0; e_wbv = 1; e_wbr = m_reg; e_wbc = m_pend;
      end
    end
  endtask

  task automatic pfx(input logic [4:0] r, input logic [15:0] t, input logic [3:0] n);
    logic [63:0] s;
    cyc(1, 1, r, t, n, 64'd0, 64'd0, s);
  endtask

  task automatic op(input logic [63:0] a, input logic [63:0] b, output logic [63:0] s);
    cyc(1, 0, 5'd0, 16'd0, 4'd0, a, b, s);
  endtask

  task automatic idle();
    logic [63:0] s;
    cyc(0, 0, 5'd0, 16'd0, 4'd0, 64'd0, 64'd0, s);
  endtask

  // R10: 4-limb add, tags slot0=01, slots1..3=11 -> 16'h00FD
  task automatic wide_add(input logic [255:0] a, input logic [255:0] b);
    logic [63:0]  s [4];
    logic [256:0] got, exp;
    pfx(5'd8, 16'h00FD, 4'd4);
    for (int i = 0; i < 4; i++) op(a[64*i +: 64], b[64*i +: 64], s[i]);
    seen_wbc = 0;
    idle();
    got = {seen_wbc, s[3], s[2], s[1], s[0]};
    exp = {1'b0, a} + {1'b0, b};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R10 sum: actual %h expected %h", got, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] s;
    logic [255:0] ra, rb;
    m_active = 0; m_left = 0; m_tags = 0; m_reg = 0; m_pend = 0;
    e_wbv = 0; e_wbc = 0; e_pre = 0; e_wbr = 0; seen_wbc = 0;
    in_valid = 0; in_is_prefix = 0; pfx_reg = 0; pfx_tags = 0; pfx_count = 0;
    ex_cout = 0;
    rst_n = 0;
    #35;
    // R1: outputs idle under reset
    chk(!cin_en && !cin_val && !wb_valid, "R1", "reset outputs",
        {cin_en, cin_val, wb_valid}, 0);
    @(negedge clk); rst_n = 1;
    // R1/R8: instruction without prefix takes no carry
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, s);
    idle();
    // R10: random and all-ones 4-limb chains
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 8; j++) begin
        ra[32*j +: 32] = $urandom;
        rb[32*j +: 32] = $urandom;
      end
      wide_add(ra, rb);
    end
    wide_add({256{1'b1}}, 256'd1);
    wide_add({256{1'b1}}, {256{1'b1}});
    // R3/R5: consume-only first slot sees zero; 00 slot keeps pending
    pfx(5'd3, 16'b00_10_00_01_10, 4'd5);
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'd5, s);
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'd5, s);
    op(64'd1, 64'd1, s);
    idle(); // R2: idle cycle consumes no slot
    op(64'd1, 64'd1, s);
    op(64'd7, 64'd7, s);
    idle();
    // R7: preempt mid-shadow
    pfx(5'd9, 16'h00FD, 4'd4);
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, s);
    op(64'd0, 64'd0, s);
    pfx(5'd10, 16'h0002, 4'd2);
    op(64'd3, 64'd4, s);
    op(64'd3, 64'd4, s);
    idle();
    // R9: zero-length prefix opens nothing
    pfx(5'd11, 16'hFFFF, 4'd0);
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, s);
    idle();
    // R2: count 12 clamps to 8 slots
    pfx(5'd12, 16'hFFFD, 4'd12);
    for (int i = 0; i < 9; i++) op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, s);
    idle();
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule